// File: doc/BRIEF.md
# Overload and Thermal Protection Sequencer

This block supervises the two outputs of a dual supply regulator. Each channel has a comparator that reports when its analog current clamp has reached its limit. In dynamic mode a persistent overload starts a hiccup retry. The output is switched off for a long interval, then switched back on for a short probe interval, and the cycle repeats until a probe passes without overload. In static mode the output stays on as a plain clamp, and the overload flag simply tracks the comparator.

A junction-temperature code is compared against a trip point and a lower release point, which gives hysteresis. While the part is hot, both outputs are forced off. On entry into the hot state, a one-cycle pulse tells the control register to wipe the host's enable bits, so the outputs remain off after cooling until the host writes the bits again. All timing counts a 1 ms tick that arrives from outside the block. The off and on lengths are parameters, with defaults of 900 and 20 ticks.

Top module: `prot_seq`

## Requirements
- R1: `limit_hi` equals `hi_limit` at all times. A value of 1 selects the high clamp band (about 775–925 mA) and 0 selects the low band (about 425–530 mA).
- R2: In dynamic mode (`static_mode`=0, soft-start done), an overload applied to `ovl_raw[i]` passes through a two-flop synchronizer. On the third rising edge after it is applied, `ch_en[i]` drops and `ovl_flag[i]` rises.
- R3: A channel stays off for exactly OFF_MS ticks. On the edge that samples the OFF_MS-th tick, it re-enables for the probe interval and `ovl_flag[i]` stays high.
- R4: If the synchronized overload is seen at any cycle of the probe interval, the channel returns to off on the edge that samples the ON_MS-th probe tick.
- R5: If a probe interval of ON_MS ticks passes with no overload, the channel returns to normal operation with `ovl_flag[i]`=0 and `ch_en[i]`=`host_en[i]`.
- R6: In static mode the channel never disables itself, and `ovl_flag[i]` equals the synchronized overload, two edges behind `ovl_raw[i]`. Setting `static_mode` during a retry re-enables the channel in the same cycle, with no clock edge needed.
- R7: While `softstart_done`=0, both overload flags are 0 and no retry runs. When `softstart_done` is first seen high, the flags reflect only the overload present at that point.
- R8: When `temp_code` > T_HOT (default 150), `hot_flag` is set on the next edge and both `ch_en` bits are 0. `hot_flag` clears only on an edge that samples `temp_code` <= T_COOL (default 135). Between the two thresholds it holds its value.
- R9: `host_clear` is high for exactly the one cycle in which `hot_flag` rises. `ch_en[i]` is always gated by `host_en[i]`, so an output stays off after cooling until its enable bit is written again.
- R10: The two channels are independent: an overload or retry on one leaves the other's enable and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| ovl_raw | input | N_CH | Asynchronous overload comparators, one per channel |
| static_mode | input | 1 | 1 = static clamp, 0 = dynamic hiccup retry |
| hi_limit | input | 1 | Clamp threshold select from the control register |
| temp_code | input | TEMP_W | Junction temperature in °C |
| softstart_done | input | 1 | Power-on soft-start has completed |
| host_en | input | N_CH | Host-written output enable bits |
| ch_en | output | N_CH | Output enables to the converter and regulator |
| limit_hi | output | 1 | Threshold select to the analog clamp |
| ovl_flag | output | N_CH | Per-channel overload flags |
| hot_flag | output | 1 | Over-temperature flag |
| host_clear | output | 1 | Pulse that clears the host enable bits |

## Verification
If a retry state machine holds the wrong state, `ch_en` goes wrong on the next cycle: the output is dark while `ovl_flag` is low, or lit in the middle of an off interval. If a tick counter has drifted, no port shows it until the end of the interval, where the re-enable or the return to off comes one tick early or late. The bench therefore checks the enable after every tick of each interval. If the thermal state is wrong, `ch_en` or `host_clear` is wrong on the edge right after the temperature crosses a threshold.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_REST  = 2'd1,
    ST_PROBE = 2'd2
  } chan_state_t;
endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/prot_chan.sv
module prot_chan
  import prot_pkg::*;
#(
  parameter int OFF_MS = 900,
  parameter int ON_MS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ovl,
  input  logic static_mode,
  input  logic ss_done,
  output logic en,
  output logic flag
);
  localparam int MAXC = (OFF_MS > ON_MS) ? OFF_MS : ON_MS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] REST_LAST  = CW'(OFF_MS - 1);
  localparam logic [CW-1:0] PROBE_LAST = CW'(ON_MS - 1);

  chan_state_t   st;
  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_RUN;
      cnt  <= '0;
      seen <= 1'b0;
    end else if (!ss_done || static_mode) begin
      st   <= ST_RUN;
      cnt  <= '0;
      seen <= 1'b0;
    end else begin
      case (st)
        ST_RUN: begin
          if (ovl) begin
            st  <= ST_REST;
            cnt <= '0;
          end
        end
        ST_REST: begin
          if (tick) begin
            if (cnt == REST_LAST) begin
              st   <= ST_PROBE;
              cnt  <= '0;
              seen <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_PROBE: begin
          seen <= seen | ovl;
          if (tick) begin
            if (cnt == PROBE_LAST) begin
              st   <= (seen | ovl) ? ST_REST : ST_RUN;
              cnt  <= '0;
              seen <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign en   = static_mode | !ss_done | (st != ST_REST);
  assign flag = ss_done & (static_mode ? ovl : (st != ST_RUN));
endmodule

// File: rtl/prot_therm.sv
module prot_therm #(
  parameter int TEMP_W = 8,
  parameter int T_HOT  = 150,
  parameter int T_COOL = 135
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp,
  output logic              hot,
  output logic              clr_pulse
);
  localparam logic [TEMP_W-1:0] HOT_C  = TEMP_W'(T_HOT);
  localparam logic [TEMP_W-1:0] COOL_C = TEMP_W'(T_COOL);

  logic over, under;
  assign over  = temp > HOT_C;
  assign under = temp <= COOL_C;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot       <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= over & ~hot;
      if (over)       hot <= 1'b1;
      else if (under) hot <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_seq.sv
module prot_seq #(
  parameter int N_CH   = 2,
  parameter int OFF_MS = 900,
  parameter int ON_MS  = 20,
  parameter int TEMP_W = 8,
  parameter int T_HOT  = 150,
  parameter int T_COOL = 135,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1ms,
  input  logic [N_CH-1:0]   ovl_raw,
  input  logic              static_mode,
  input  logic              hi_limit,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              softstart_done,
  input  logic [N_CH-1:0]   host_en,
  output logic [N_CH-1:0]   ch_en,
  output logic              limit_hi,
  output logic [N_CH-1:0]   ovl_flag,
  output logic              hot_flag,
  output logic              host_clear
);
  logic [N_CH-1:0] ovl_s;
  logic [N_CH-1:0] fsm_en;

  prot_sync #(.W(N_CH), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ovl_raw), .q(ovl_s)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    prot_chan #(.OFF_MS(OFF_MS), .ON_MS(ON_MS)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .ovl(ovl_s[i]),
      .static_mode(static_mode), .ss_done(softstart_done),
      .en(fsm_en[i]), .flag(ovl_flag[i])
    );
  end

  prot_therm #(.TEMP_W(TEMP_W), .T_HOT(T_HOT), .T_COOL(T_COOL)) u_therm (
    .clk(clk), .rst_n(rst_n), .temp(temp_code),
    .hot(hot_flag), .clr_pulse(host_clear)
  );

  assign ch_en    = fsm_en & host_en & {N_CH{~hot_flag}};
  assign limit_hi = hi_limit;
endmodule

// File: rtl/prot_seq_chk.sv
module prot_seq_chk #(
  parameter int N_CH   = 2,
  parameter int TEMP_W = 8,
  parameter int T_HOT  = 150,
  parameter int T_COOL = 135
) (
  input logic              clk,
  input logic              rst_n,
  input logic              static_mode,
  input logic              hi_limit,
  input logic [TEMP_W-1:0] temp_code,
  input logic              softstart_done,
  input logic [N_CH-1:0]   host_en,
  input logic [N_CH-1:0]   ch_en,
  input logic              limit_hi,
  input logic [N_CH-1:0]   ovl_flag,
  input logic              hot_flag,
  input logic              host_clear
);
  // R1
  limit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hi == hi_limit);

  // R8
  hot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag |-> (ch_en == '0));

  // R8
  hot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > TEMP_W'(T_HOT)) |=> hot_flag);

  // R8
  hot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_flag && temp_code > TEMP_W'(T_COOL)) |=> hot_flag);

  // R9
  clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |-> $rose(hot_flag));

  // R9
  clear_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_flag) |-> host_clear);

  // R7
  softstart_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !softstart_done |-> (ovl_flag == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R6
    static_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (static_mode && host_en[i] && !hot_flag) |-> ch_en[i]);

    // R2
    dark_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_en[i] && !hot_flag && !ch_en[i]) |-> ovl_flag[i]);
  end
endmodule

bind prot_seq prot_seq_chk #(
  .N_CH(N_CH), .TEMP_W(TEMP_W), .T_HOT(T_HOT), .T_COOL(T_COOL)
) u_prot_chk (
  .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .hi_limit(hi_limit),
  .temp_code(temp_code), .softstart_done(softstart_done), .host_en(host_en),
  .ch_en(ch_en), .limit_hi(limit_hi), .ovl_flag(ovl_flag),
  .hot_flag(hot_flag), .host_clear(host_clear)
);

// File: tb/tb_prot_seq.sv
module tb_prot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int OFFN = 5;
  localparam int ONN  = 3;
  localparam int HOT  = 150;
  localparam int COOL = 135;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick_1ms = 1'b0;
  logic [NCH-1:0] ovl_raw = '0;
  logic           static_mode = 1'b0;
  logic           hi_limit = 1'b0;
  logic [7:0]     temp_code = 8'd25;
  logic           softstart_done = 1'b0;
  logic [NCH-1:0] host_en = 2'b11;
  logic [NCH-1:0] ch_en;
  logic           limit_hi;
  logic [NCH-1:0] ovl_flag;
  logic           hot_flag;
  logic           host_clear;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_seq #(.N_CH(NCH), .OFF_MS(OFFN), .ON_MS(ONN), .TEMP_W(8),
             .T_HOT(HOT), .T_COOL(COOL), .SYNC_N(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .ovl_raw(ovl_raw),
    .static_mode(static_mode), .hi_limit(hi_limit), .temp_code(temp_code),
    .softstart_done(softstart_done), .host_en(host_en), .ch_en(ch_en),
    .limit_hi(limit_hi), .ovl_flag(ovl_flag), .hot_flag(hot_flag),
    .host_clear(host_clear)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic tick();
    tick_1ms = 1'b1;
    step(1);
    tick_1ms = 1'b0;
    step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // reset state
    chk("R7 reset flags", {6'd0, ovl_flag}, 8'd0);
    chk("R9 reset en", {6'd0, ch_en}, 8'd3);
    chk("R8 reset hot", {7'd0, hot_flag}, 8'd0);

    // R1 sweep
    for (int v = 0; v < 2; v++) begin
      hi_limit = v[0];
      #1;
      chk("R1 limit", {7'd0, limit_hi}, {7'd0, v[0]});
    end

    // R7: overload before soft-start done is ignored
    ovl_raw = 2'b01;
    step(4);
    for (int k = 0; k < OFFN + 2; k++) tick();
    chk("R7 flag held low", {6'd0, ovl_flag}, 8'd0);
    chk("R7 no retry", {6'd0, ch_en}, 8'd3);

    // R2: soft-start done with overload already synchronized
    softstart_done = 1'b1;
    step(1);
    chk("R2 ch0 off", {6'd0, ch_en}, 8'd2);
    chk("R2 ch0 flag", {6'd0, ovl_flag}, 8'd1);

    // R3/R4: several retry cycles with overload held
    for (int cyc = 0; cyc < 2; cyc++) begin
      for (int k = 1; k <= OFFN; k++) begin
        tick();
        chk("R3 rest length", {7'd0, ch_en[0]}, (k == OFFN) ? 8'd1 : 8'd0);
        chk("R3 flag high", {7'd0, ovl_flag[0]}, 8'd1);
        chk("R10 ch1 untouched", {6'd0, ch_en[1], ovl_flag[1]}, 8'd2);
      end
      for (int k = 1; k <= ONN; k++) begin
        tick();
        chk("R4 probe length", {7'd0, ch_en[0]}, (k == ONN) ? 8'd0 : 8'd1);
      end
    end

    // R5: clear overload during rest, probe passes clean
    ovl_raw = 2'b00;
    for (int k = 1; k <= OFFN; k++) tick();
    chk("R3 probe on", {7'd0, ch_en[0]}, 8'd1);
    for (int k = 1; k <= ONN; k++) tick();
    chk("R5 normal flag", {7'd0, ovl_flag[0]}, 8'd0);
    chk("R5 normal en", {7'd0, ch_en[0]}, 8'd1);

    // R4: short glitch inside the probe
    ovl_raw = 2'b01;
    step(3);
    chk("R2 off again", {7'd0, ch_en[0]}, 8'd0);
    ovl_raw = 2'b00;
    for (int k = 1; k <= OFFN; k++) tick();
    tick();
    ovl_raw = 2'b01;
    step(1);
    ovl_raw = 2'b00;
    step(4);
    chk("R4 still probing", {7'd0, ch_en[0]}, 8'd1);
    for (int k = 2; k <= ONN; k++) tick();
    chk("R4 glitch forces rest", {7'd0, ch_en[0]}, 8'd0);

    // R6: switch to static during rest
    static_mode = 1'b1;
    #1;
    chk("R6 immediate on", {7'd0, ch_en[0]}, 8'd1);
    chk("R6 flag follows clear", {7'd0, ovl_flag[0]}, 8'd0);
    ovl_raw = 2'b11;
    step(1);
    chk("R6 flag latency", {6'd0, ovl_flag}, 8'd0);
    step(1);
    chk("R6 flag set", {6'd0, ovl_flag}, 8'd3);
    for (int k = 0; k < OFFN + ONN; k++) tick();
    chk("R6 en held", {6'd0, ch_en}, 8'd3);
    ovl_raw = 2'b00;
    step(2);
    chk("R6 flag clears", {6'd0, ovl_flag}, 8'd0);

    // R10: both overloaded in dynamic, only ch1 persists
    static_mode = 1'b0;
    ovl_raw = 2'b11;
    step(3);
    chk("R10 both off", {6'd0, ch_en}, 8'd0);
    ovl_raw = 2'b10;
    for (int k = 0; k < OFFN + ONN; k++) tick();
    chk("R10 ch0 recovers ch1 rests", {6'd0, ch_en}, 8'd1);
    chk("R10 flags", {6'd0, ovl_flag}, 8'd2);
    ovl_raw = 2'b00;
    for (int k = 0; k < OFFN + ONN; k++) tick();
    chk("R5 ch1 recovers", {6'd0, ovl_flag, ch_en}, 8'd3);

    // R8/R9: temperature sweep up then down
    begin
      bit exp_hot = 0;
      bit prev_hot;
      for (int t = 128; t <= 160; t++) begin
        temp_code = t[7:0];
        prev_hot = exp_hot;
        if (t > HOT) exp_hot = 1;
        else if (t <= COOL) exp_hot = 0;
        step(1);
        chk("R8 hot up", {7'd0, hot_flag}, {7'd0, exp_hot});
        chk("R9 clear pulse", {7'd0, host_clear}, {7'd0, exp_hot & ~prev_hot});
        if (host_clear) host_en = 2'b00;
        if (exp_hot) chk("R8 outputs off", {6'd0, ch_en}, 8'd0);
      end
      for (int t = 160; t >= 128; t--) begin
        temp_code = t[7:0];
        if (t > HOT) exp_hot = 1;
        else if (t <= COOL) exp_hot = 0;
        step(1);
        chk("R8 hot down", {7'd0, hot_flag}, {7'd0, exp_hot});
        chk("R9 no clear on cool", {7'd0, host_clear}, 8'd0);
      end
    end
    chk("R9 stays off after cool", {6'd0, ch_en}, 8'd0);
    host_en = 2'b11;
    #1;
    chk("R9 on after rewrite", {6'd0, ch_en}, 8'd3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule